// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates the interrupt requests of a small 8-bit microcontroller core. Four sources feed it: two timer overflow flags, a serial port status pair and a third timer flag. Two byte-wide configuration registers are applied to those requests. The enable register has a master bit and one bit for each source. The priority register places each source in the high level or the low level. On each machine-cycle strobe the block decides whether to divert the core. When it accepts a request, it does four things:
- issues a one-cycle take pulse with the vector address;
- writes the interrupted program counter onto the stack as two bytes on two consecutive cycles;
- raises the in-service level;
- pulses a clear for the serviced timer flag where the hardware is responsible for clearing it.

Selection is fixed-order polling inside each level, and the high level is polled first. An accepted request may interrupt a running handler only if the handler runs at a strictly lower level. A return strobe restores the level that was interrupted, using a small in-service stack, and gives back the two stack bytes. The block owns the stack pointer. The stack memory itself lives outside it.

Top module: `irq_vec_ctrl`

## Requirements
- R1: When bit 7 of `ie_cfg` is 0, no request is accepted, whatever the other enable bits hold.
- R2: Each source uses the same bit position in `ie_cfg` and `ip_cfg`: timer 0 bit 1, timer 1 bit 3, serial bit 4, timer 2 bit 5. A source whose enable bit is 0 is never accepted. The serial request is the OR of both `ser_stat` bits.
- R3: The high level (priority bit 1) is polled before the low level (priority bit 0). Within one level the first pending, enabled source in the order timer 0, timer 1, serial, timer 2 wins.
- R4: A level is polled only when the current in-service level is strictly below it. A request at the same or a lower level than the running handler waits.
- R5: A request sampled with `cyc_en` high is accepted on that clock edge. `take_o` is high for one cycle after that edge, and `vec_o` holds 0x0B, 0x1B, 0x23 or 0x2B for timer 0, timer 1, serial or timer 2.
- R6: The stack write has two parts. In the `take_o` cycle, `pc_in[7:0]` is written at `sp_o`+1. In the following cycle, `pc_in[15:8]` (captured at acceptance) is written at the old `sp_o`+2, and `sp_o` advances by 2. `sp_o` resets to 0x07.
- R7: `act_lvl_o` encodes the in-service level as 0 = none, 1 = low, 2 = high. It takes the accepted level together with `take_o`.
- R8: Accepting timer 0 pulses `clr_tf0_o`, and accepting timer 1 pulses `clr_tf1_o`, each in the `take_o` cycle. Accepting serial or timer 2 pulses neither clear.
- R9: `reti` restores `act_lvl_o` to the level that was in service before the latest acceptance and lowers `sp_o` by 2. With nothing in service, `reti` changes neither.
- R10: No request is accepted in a cycle where `cyc_en` is 0, in the cycle that writes the high byte, or in a cycle where `reti` is 1.
- R11: After reset, `take_o`, both clears and `stk_we_o` are 0, `act_lvl_o` is 0 and `sp_o` is 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Machine-cycle strobe; arbitration happens only when high |
| ie_cfg | input | 8 | Enable register (bit 7 master, bits 1/3/4/5 per source) |
| ip_cfg | input | 8 | Priority register (bits 1/3/4/5, 1 = high level) |
| tf0_req | input | 1 | Timer 0 overflow request |
| tf1_req | input | 1 | Timer 1 overflow request |
| ser_stat | input | 2 | Serial receive/transmit status; either bit requests |
| tf2_req | input | 1 | Timer 2 request |
| reti | input | 1 | Return-from-interrupt strobe |
| pc_in | input | 16 | Program counter to save on acceptance |
| take_o | output | 1 | One-cycle pulse: load the program counter with `vec_o` |
| vec_o | output | 16 | Vector address of the accepted source |
| clr_tf0_o | output | 1 | Pulse clearing the timer 0 flag |
| clr_tf1_o | output | 1 | Pulse clearing the timer 1 flag |
| stk_we_o | output | 1 | Stack byte write enable |
| stk_addr_o | output | 8 | Stack byte address |
| stk_data_o | output | 8 | Stack byte data |
| sp_o | output | 8 | Current stack pointer |
| act_lvl_o | output | 2 | In-service level (0 none, 1 low, 2 high) |

## Verification
The bench raises all four sources at once at one level. A design with a reversed or broken polling order would vector to the wrong address and clear the wrong flag. It also pits a low request against a high one, holds equal-level requests against a running handler, and raises a high request during the high-byte write cycle. A wrong comparison in the preemption rule would nest at an equal level or stall a legal preemption. Any of these faults would also move the stack pointer off by two. The bench also sends return strobes when nothing is in service and in the same cycle as a pending strobe. A design that let the level or pointer underflow, or that accepted alongside a return, would fail there. The last test exits two nested handlers in turn, to catch a level stack that restores the wrong level.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC    = 4;
  localparam int GIE_BIT = 7;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_LO   = 2'd1;
  localparam lvl_t LVL_HI   = 2'd2;

  // bit position of a source in both configuration registers; polling order = index
  function automatic int src_bit(input int s);
    case (s)
      0:       return 1;
      1:       return 3;
      2:       return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/irq_arb.sv
module irq_arb
  import irq_vec_pkg::*;
#(
  parameter int VEC_W = 16,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [7:0]       ie_cfg,
  input  logic [7:0]       ip_cfg,
  input  logic [NSRC-1:0]  req,
  input  lvl_t             act,
  output logic             hit,
  output lvl_t             hit_lvl,
  output logic [IDX_W-1:0] hit_idx,
  output logic [VEC_W-1:0] hit_vec
);
  logic [NSRC-1:0]  en;
  logic [NSRC-1:0]  pr;
  logic [VEC_W-1:0] vtab [NSRC];

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign en[s]   = ie_cfg[src_bit(s)];
      assign pr[s]   = ip_cfg[src_bit(s)];
      assign vtab[s] = VEC_W'(8 * src_bit(s) + 3);
    end
  endgenerate

  logic [NSRC-1:0] pend_hi, pend_lo, cand;

  always_comb begin
    pend_hi = req & en & pr  & {NSRC{ie_cfg[GIE_BIT]}};
    pend_lo = req & en & ~pr & {NSRC{ie_cfg[GIE_BIT]}};
    hit     = 1'b0;
    hit_lvl = LVL_NONE;
    cand    = '0;
    if ((act < LVL_HI) && (|pend_hi)) begin
      hit = 1'b1; hit_lvl = LVL_HI; cand = pend_hi;
    end else if ((act < LVL_LO) && (|pend_lo)) begin
      hit = 1'b1; hit_lvl = LVL_LO; cand = pend_lo;
    end
    hit_idx = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (cand[s]) hit_idx = IDX_W'(s);
    end
    hit_vec = vtab[hit_idx];
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_vec_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  lvl_t push_val,
  input  logic pop,
  output lvl_t top,
  output logic nonempty
);
  lvl_t          mem [DEPTH];
  logic [PW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (push) mem[IW'(ptr)] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (push) ptr <= ptr + PW'(1);
    else if (pop)  ptr <= ptr - PW'(1);
  end

  assign nonempty = (ptr != '0);
  assign top      = nonempty ? mem[IW'(ptr - PW'(1))] : LVL_NONE;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int          PC_W   = 16,
  parameter int          SP_W   = 8,
  parameter logic [7:0]  SP_RST = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cyc_en,
  input  logic [7:0]      ie_cfg,
  input  logic [7:0]      ip_cfg,
  input  logic            tf0_req,
  input  logic            tf1_req,
  input  logic [1:0]      ser_stat,
  input  logic            tf2_req,
  input  logic            reti,
  input  logic [PC_W-1:0] pc_in,
  output logic            take_o,
  output logic [PC_W-1:0] vec_o,
  output logic            clr_tf0_o,
  output logic            clr_tf1_o,
  output logic            stk_we_o,
  output logic [SP_W-1:0] stk_addr_o,
  output logic [7:0]      stk_data_o,
  output logic [SP_W-1:0] sp_o,
  output logic [1:0]      act_lvl_o
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int NLVL  = 2;

  logic [NSRC-1:0]  req;
  logic             hit;
  lvl_t             hit_lvl;
  logic [IDX_W-1:0] hit_idx;
  logic [PC_W-1:0]  hit_vec;
  lvl_t             act;
  lvl_t             stk_top;
  logic             stk_ne;
  logic             busy;
  logic [7:0]       hi_hold;
  logic             accept, release_lvl;

  assign req = {tf2_req, |ser_stat, tf1_req, tf0_req};

  irq_arb #(.VEC_W(PC_W)) u_arb (
    .ie_cfg (ie_cfg),
    .ip_cfg (ip_cfg),
    .req    (req),
    .act    (act),
    .hit    (hit),
    .hit_lvl(hit_lvl),
    .hit_idx(hit_idx),
    .hit_vec(hit_vec)
  );

  assign accept      = !busy && !reti && cyc_en && hit;
  assign release_lvl = !busy && reti && stk_ne;

  irq_lvl_stack #(.DEPTH(NLVL)) u_lvl (
    .clk     (clk),
    .rst     (rst),
    .push    (accept),
    .push_val(act),
    .pop     (release_lvl),
    .top     (stk_top),
    .nonempty(stk_ne)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o     <= 1'b0;
      vec_o      <= '0;
      clr_tf0_o  <= 1'b0;
      clr_tf1_o  <= 1'b0;
      stk_we_o   <= 1'b0;
      stk_addr_o <= '0;
      stk_data_o <= '0;
      sp_o       <= SP_W'(SP_RST);
      act        <= LVL_NONE;
      busy       <= 1'b0;
      hi_hold    <= '0;
    end else begin
      take_o    <= 1'b0;
      clr_tf0_o <= 1'b0;
      clr_tf1_o <= 1'b0;
      stk_we_o  <= 1'b0;
      if (busy) begin
        stk_we_o   <= 1'b1;
        stk_addr_o <= sp_o + SP_W'(2);
        stk_data_o <= hi_hold;
        sp_o       <= sp_o + SP_W'(2);
        busy       <= 1'b0;
      end else if (reti) begin
        if (stk_ne) begin
          act  <= stk_top;
          sp_o <= sp_o - SP_W'(2);
        end
      end else if (accept) begin
        take_o     <= 1'b1;
        vec_o      <= hit_vec;
        clr_tf0_o  <= (hit_idx == IDX_W'(0));
        clr_tf1_o  <= (hit_idx == IDX_W'(1));
        stk_we_o   <= 1'b1;
        stk_addr_o <= sp_o + SP_W'(1);
        stk_data_o <= pc_in[7:0];
        hi_hold    <= pc_in[15:8];
        busy       <= 1'b1;
        act        <= hit_lvl;
      end
    end
  end

  assign act_lvl_o = act;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  ie_cfg,
  input logic        reti,
  input logic        take_o,
  input logic        clr_tf0_o,
  input logic        clr_tf1_o,
  input logic        stk_we_o,
  input logic [7:0]  stk_addr_o,
  input logic [7:0]  sp_o,
  input logic [1:0]  act_lvl_o
);
  // R1: acceptance needs the master enable at the sampling edge
  a_r1_gie_needed: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(ie_cfg[7]));

  // R6: high byte follows at the next address, pointer moves by two
  a_r6_second_byte: assert property (@(posedge clk) disable iff (rst)
    take_o |=> (stk_we_o && stk_addr_o == $past(stk_addr_o) + 8'd1));
  a_r6_sp_advance: assert property (@(posedge clk) disable iff (rst)
    take_o |=> (sp_o == $past(sp_o) + 8'd2));

  // R4 / R7: an acceptance always raises the in-service level
  a_r4_strict_raise: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (act_lvl_o > $past(act_lvl_o)));

  // R8: clears only alongside an acceptance, never both
  a_r8_clr_with_take: assert property (@(posedge clk) disable iff (rst)
    (clr_tf0_o || clr_tf1_o) |-> take_o);
  a_r8_clr_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clr_tf0_o, clr_tf1_o}));

  // R9: the level drops only after a return strobe
  a_r9_drop_on_reti: assert property (@(posedge clk) disable iff (rst)
    (act_lvl_o < $past(act_lvl_o)) |-> $past(reti));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk chk_i (.*);

// File: tb/irq_vec_ctrl_test.sv
`timescale 1ns/1ps
module irq_vec_ctrl_test;
  logic clk = 0, rst = 1, cyc_en = 0, reti = 0;
  logic [7:0] ie_cfg = 0, ip_cfg = 0;
  logic tf0_req = 0, tf1_req = 0, tf2_req = 0;
  logic [1:0] ser_stat = 0;
  logic [15:0] pc_in = 16'h1234;
  logic take_o, clr_tf0_o, clr_tf1_o, stk_we_o;
  logic [15:0] vec_o;
  logic [7:0] stk_addr_o, stk_data_o, sp_o;
  logic [1:0] act_lvl_o;

  int checks = 0, errors = 0;
  string scen = "R11";
  bit started = 0, done = 0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl uut (.*);

  // behavioural reference
  int m_act, m_sp, m_hi;
  int lvlq[$];
  bit m_busy, e_take, e_clr0, e_clr1, e_we;
  int e_vec, e_addr, e_data;
  int sbit[4] = '{1, 3, 4, 5};

  always @(posedge clk) begin
    bit rq[4];
    bit found;
    rq = '{tf0_req, tf1_req, |ser_stat, tf2_req};
    started = 1;
    if (rst) begin
      m_act = 0; m_sp = 7; m_busy = 0; lvlq.delete();
      e_take = 0; e_clr0 = 0; e_clr1 = 0; e_we = 0;
    end else begin
      e_take = 0; e_clr0 = 0; e_clr1 = 0; e_we = 0;
      if (m_busy) begin
        e_we = 1; e_addr = (m_sp + 2) % 256; e_data = m_hi;
        m_sp = (m_sp + 2) % 256; m_busy = 0;
      end else if (reti) begin
        if (lvlq.size() > 0) begin
          m_act = lvlq.pop_back(); m_sp = (m_sp + 254) % 256;
        end
      end else if (cyc_en && ie_cfg[7]) begin
        found = 0;
        for (int lv = 2; lv >= 1; lv--) begin
          if (!found && m_act < lv) begin
            for (int s = 0; s < 4; s++) begin
              if (!found && rq[s] && ie_cfg[sbit[s]] && (ip_cfg[sbit[s]] == (lv == 2))) begin
                found = 1;
                lvlq.push_back(m_act); m_act = lv;
                e_take = 1; e_vec = 8 * sbit[s] + 3;
                e_clr0 = (s == 0); e_clr1 = (s == 1);
                e_we = 1; e_addr = (m_sp + 1) % 256; e_data = pc_in[7:0];
                m_hi = pc_in[15:8]; m_busy = 1;
              end
            end
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (scenario %s) at %0t: actual %0h expected %0h", tag, scen, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(take_o == e_take, "R5 take", take_o, e_take);
      if (e_take) chk(vec_o == 16'(e_vec), "R5 vector", vec_o, e_vec);
      chk(clr_tf0_o == e_clr0, "R8 clr0", clr_tf0_o, e_clr0);
      chk(clr_tf1_o == e_clr1, "R8 clr1", clr_tf1_o, e_clr1);
      chk(stk_we_o == e_we, "R6 we", stk_we_o, e_we);
      if (e_we) begin
        chk(stk_addr_o == 8'(e_addr), "R6 addr", stk_addr_o, e_addr);
        chk(stk_data_o == 8'(e_data), "R6 data", stk_data_o, e_data);
      end
      chk(sp_o == 8'(m_sp), "R6 sp", sp_o, m_sp);
      chk(act_lvl_o == 2'(m_act), "R7 level", act_lvl_o, m_act);
    end
  end

  task automatic nxt(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int n = 1);
    cyc_en = 1; nxt(n); cyc_en = 0; nxt(2);
  endtask

  task automatic ret();
    reti = 1; nxt(); reti = 0; nxt();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    nxt(3); rst = 0; nxt(2);
    // R1: master enable off blocks everything
    scen = "R1"; ie_cfg = 8'h02; tf0_req = 1; pulse();
    // R2: master on, source bit off
    scen = "R2"; ie_cfg = 8'h80; pulse();
    // R5/R8: timer 0 low accepted
    scen = "R5"; ie_cfg = 8'h82; pc_in = 16'hA5C3; pulse(); tf0_req = 0;
    // R4: equal level waits, high preempts, high does not preempt high
    scen = "R4"; ie_cfg = 8'hAA; tf1_req = 1; pulse();
    ip_cfg = 8'h20; tf2_req = 1; pc_in = 16'h0F10; pulse(); tf2_req = 0;
    ip_cfg = 8'h28; pulse(); ip_cfg = 8'h00;
    // R9: unwind both levels, extra return ignored
    scen = "R9"; ret(); ret(); ret();
    // R10: return wins over a pending acceptance; no strobe, no decision
    scen = "R10"; cyc_en = 1; reti = 1; nxt(); cyc_en = 0; reti = 0; nxt(3);
    pulse(); tf1_req = 0; ret();
    // R10: high request arriving during high-byte write is ignored there
    ie_cfg = 8'hA2; ip_cfg = 8'h20; tf0_req = 1; cyc_en = 1; nxt(); tf2_req = 1; nxt(); cyc_en = 0;
    tf0_req = 0; nxt(); pulse(); tf2_req = 0; ret(); ret();
    // R3: fixed order within the low level
    scen = "R3"; ie_cfg = 8'hBA; ip_cfg = 8'h00;
    tf0_req = 1; tf1_req = 1; ser_stat = 2'b01; tf2_req = 1; pc_in = 16'h7E81;
    pulse(); tf0_req = 0; ret();
    pulse(); tf1_req = 0; ret();
    pulse(); ser_stat = 2'b10; ret();
    pulse(); ser_stat = 2'b00; ret();
    pulse(); ret();
    // R3: high level before low level
    ip_cfg = 8'h20; tf0_req = 1; tf2_req = 1; pulse(); pulse(); tf2_req = 0; ret();
    pulse(); tf0_req = 0; ret(); nxt(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule